// File: doc/BRIEF.md
# Monitor Mode Entry Controller

This block decides, each time the external reset pin is released, whether a small microcontroller core starts in monitor (debug) mode or in user mode. It holds that decision and records why monitor mode was entered: a high-voltage test level on the interrupt pin together with a mode-select pattern, or an erased reset vector. The recorded cause sets how long the watchdog stays disabled and whether a later pin reset can leave monitor mode.

While monitor mode is active, CPU vector fetches of the reset, software-interrupt and break vectors are moved one page down in the address map, so that the core starts from the monitor firmware rather than from user code. Ordinary data reads and fetches of other vectors pass through unchanged. A power-on reset pulse always returns the block to user mode. The next pin release then makes a new decision.

Top module: `mon_entry_ctrl`

## Requirements
- R1: After the chip reset `rst_n` is released, `mon_mode` and `wdog_dis` are 0 and `xlat_addr` equals `vf_addr`.
- R2: The decision is taken on the rising edge of `rst_pin`, after a synchronizer of `SYNC_STAGES` flops plus one edge-detect flop. It is visible on `mon_mode` at most `SYNC_STAGES`+1 clocks after the pin rises. After that, changes on `mode_sel`, `hv_irq`, `hv_rst` and `vec_blank` leave `mon_mode` unchanged.
- R3: If `vec_blank` is 0 at the decision edge, monitor mode is entered only when `hv_irq` is 1 and `mode_sel` equals 2'b10. Any other combination (for example `mode_sel` 2'b11, or `hv_irq` 0) selects user mode.
- R4: If `vec_blank` is 1 at the decision edge, monitor mode is entered whatever `hv_irq` and `mode_sel` are.
- R5: `wdog_dis` is 0 in user mode. It is 1 at all times after blank-vector entry. After test-voltage entry it is 1 exactly while `hv_irq` or `hv_rst` is 1.
- R6: After blank-vector entry, further reset-pin releases keep monitor mode whatever the inputs are. After test-voltage entry, a later release decides again and can return to user mode.
- R7: A one-cycle `por` pulse returns the block to user mode on the next clock, from any cause. The next pin release then decides again.
- R8: In monitor mode, a vector fetch (`vf_valid`=1) of 0xFFFC, 0xFFFD, 0xFFFE or 0xFFFF gives 0xFEFC, 0xFEFD, 0xFEFE or 0xFEFF on `xlat_addr`. In user mode these addresses pass unchanged.
- R9: With `vf_valid`=0, or for a vector fetch outside 0xFFFC to 0xFFFF (such as 0xFFFA), `xlat_addr` equals `vf_addr` even in monitor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous assert and synchronous release |
| por | input | 1 | Power-on reset pulse, clears the mode |
| rst_pin | input | 1 | External reset pin level (low = held in reset) |
| hv_irq | input | 1 | Test high voltage detected on the interrupt pin |
| hv_rst | input | 1 | Test high voltage detected on the reset pin |
| mode_sel | input | 2 | Mode-select pins sampled at the decision |
| vec_blank | input | 1 | Both reset vector bytes read as erased |
| vf_valid | input | 1 | Current CPU access is a vector fetch |
| vf_addr | input | 16 | Address issued by the CPU |
| mon_mode | output | 1 | Monitor mode active |
| wdog_dis | output | 1 | Watchdog disable |
| xlat_addr | output | 16 | Address after vector remapping |

## Verification
The decision is tried with each entry pattern: a test voltage with the correct select code, a test voltage with a wrong select code, the correct code without the voltage, and an erased vector with neither. This separates the two monitor causes from each other and from user mode. The watchdog output is then followed while the voltage qualifiers are switched after each kind of entry, which shows whether the live-pin dependency is tied to the right cause. Releasing the pin again after each kind of entry, and pulsing power-on reset, separates the sticky cause from the cause that can be re-decided. Address checks cover all four remapped vectors, a neighbouring vector and non-fetch reads, in both modes.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_HV    = 2'b01,
    CAUSE_BLANK = 2'b10
  } entry_cause_e;
endpackage

// File: rtl/mme_sync.sv
module mme_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= RST_VAL;
        else         s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] s_q;
      logic [STAGES-1:0] s_d;
      always_comb s_d = {s_q[STAGES-2:0], d};
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= {STAGES{RST_VAL}};
        else         s_q <= s_d;
      end
      assign q = s_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mme_cause_reg.sv
module mme_cause_reg
  import mon_entry_pkg::*;
#(
  parameter int             MODE_W  = 2,
  parameter logic [MODE_W-1:0] MON_SEL = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por,
  input  logic              pin_s,
  input  logic              hv_irq,
  input  logic              vec_blank,
  input  logic [MODE_W-1:0] mode_sel,
  output entry_cause_e      cause
);
  logic         pin_q;
  logic         pin_rise;
  entry_cause_e cause_q, cause_d;
  logic         cause_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_s;
  end

  assign pin_rise = pin_s & ~pin_q;
  assign cause_en = por | pin_rise;

  always_comb begin
    cause_d = cause_q;
    if (por) begin
      cause_d = CAUSE_NONE;
    end else if (pin_rise && cause_q != CAUSE_BLANK) begin
      if (vec_blank)                         cause_d = CAUSE_BLANK;
      else if (hv_irq && mode_sel == MON_SEL) cause_d = CAUSE_HV;
      else                                   cause_d = CAUSE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= CAUSE_NONE;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause = cause_q;

  // R6: blank-vector entry survives everything except power-on reset
  a_r6_blank_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q == CAUSE_BLANK && !por) |=> (cause_q == CAUSE_BLANK));

  // R7: power-on reset returns to user mode
  a_r7_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> (cause_q == CAUSE_NONE));

  // R2: no change of mode without a pin release or power-on reset
  a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (!por && !(pin_s && !pin_q)) |=> $stable(cause_q));
endmodule

// File: rtl/mme_wdog_gate.sv
module mme_wdog_gate
  import mon_entry_pkg::*;
(
  input  entry_cause_e cause,
  input  logic         hv_irq,
  input  logic         hv_rst,
  output logic         wdog_dis
);
  always_comb begin
    unique case (cause)
      CAUSE_BLANK: wdog_dis = 1'b1;
      CAUSE_HV:    wdog_dis = hv_irq | hv_rst;
      default:     wdog_dis = 1'b0;
    endcase
  end
endmodule

// File: rtl/mme_vec_xlat.sv
module mme_vec_xlat #(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-9:0] VEC_PAGE     = '1,
  parameter logic [7:0]        VEC_LO_FIRST = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_mode,
  input  logic              vf_valid,
  input  logic [ADDR_W-1:0] vf_addr,
  output logic [ADDR_W-1:0] xlat_addr
);
  localparam int                PAGE_W   = ADDR_W - 8;
  localparam logic [PAGE_W-1:0] MON_PAGE = VEC_PAGE - 1'b1;

  logic is_remap;

  always_comb begin
    is_remap  = mon_mode && vf_valid &&
                (vf_addr[ADDR_W-1:8] == VEC_PAGE) &&
                (vf_addr[7:0] >= VEC_LO_FIRST);
    xlat_addr = vf_addr;
    if (is_remap) xlat_addr[ADDR_W-1:8] = MON_PAGE;
  end

  // R8: remapping never touches the offset inside the page
  a_r8_low_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_addr[7:0] == vf_addr[7:0]);
endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter int MODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por,
  input  logic              rst_pin,
  input  logic              hv_irq,
  input  logic              hv_rst,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              vec_blank,
  input  logic              vf_valid,
  input  logic [ADDR_W-1:0] vf_addr,
  output logic              mon_mode,
  output logic              wdog_dis,
  output logic [ADDR_W-1:0] xlat_addr
);
  localparam logic [MODE_W-1:0] MON_SEL = MODE_W'(2'b10);

  logic         rst_n_s;
  logic         pin_s;
  entry_cause_e cause;

  mme_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  mme_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .arst_n(rst_n_s), .d(rst_pin), .q(pin_s)
  );

  mme_cause_reg #(.MODE_W(MODE_W), .MON_SEL(MON_SEL)) u_cause (
    .clk(clk), .rst_n(rst_n_s), .por(por), .pin_s(pin_s),
    .hv_irq(hv_irq), .vec_blank(vec_blank), .mode_sel(mode_sel),
    .cause(cause)
  );

  assign mon_mode = (cause != CAUSE_NONE);

  mme_wdog_gate u_wdog (
    .cause(cause), .hv_irq(hv_irq), .hv_rst(hv_rst), .wdog_dis(wdog_dis)
  );

  mme_vec_xlat #(.ADDR_W(ADDR_W)) u_xlat (
    .clk(clk), .rst_n(rst_n_s), .mon_mode(mon_mode), .vf_valid(vf_valid),
    .vf_addr(vf_addr), .xlat_addr(xlat_addr)
  );

  // R8: user mode leaves every address unchanged
  a_r8_user_passthru: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mon_mode |-> (xlat_addr == vf_addr));

  // R9: only vector fetches are remapped
  a_r9_data_passthru: assert property (@(posedge clk) disable iff (!rst_n_s)
    !vf_valid |-> (xlat_addr == vf_addr));

  // R5: watchdog stays disabled after blank-vector entry
  a_r5_blank_wdog: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cause == CAUSE_BLANK && !por) |=> wdog_dis);

  // R5: user mode never disables the watchdog
  a_r5_user_wdog: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mon_mode |-> !wdog_dis);
endmodule

// File: tb/mon_entry_ctrl_tb_top.sv
module mon_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, por, rst_pin, hv_irq, hv_rst, vec_blank, vf_valid;
  logic [1:0]  mode_sel;
  logic [15:0] vf_addr;
  logic        mon_mode, wdog_dis;
  logic [15:0] xlat_addr;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mon_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .por(por), .rst_pin(rst_pin),
    .hv_irq(hv_irq), .hv_rst(hv_rst), .mode_sel(mode_sel),
    .vec_blank(vec_blank), .vf_valid(vf_valid), .vf_addr(vf_addr),
    .mon_mode(mon_mode), .wdog_dis(wdog_dis), .xlat_addr(xlat_addr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pin_release();
    rst_pin = 1'b0;
    cycles(4);
    rst_pin = 1'b1;
    cycles(4);
  endtask

  task automatic por_pulse();
    por = 1'b1;
    cycles(1);
    por = 1'b0;
    cycles(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; por = 1'b0; rst_pin = 1'b1; hv_irq = 1'b0; hv_rst = 1'b0;
    mode_sel = 2'b00; vec_blank = 1'b0; vf_valid = 1'b1; vf_addr = 16'hFFFE;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    check("R1 mon_mode", 16'(mon_mode), 16'h0);
    check("R1 wdog_dis", 16'(wdog_dis), 16'h0);
    check("R1 xlat_addr", xlat_addr, 16'hFFFE);
  endtask

  task automatic t_user_entry();
    hv_irq = 1'b1; mode_sel = 2'b11; vec_blank = 1'b0;
    pin_release();
    check("R3 wrong select gives user", 16'(mon_mode), 16'h0);
    hv_irq = 1'b0; mode_sel = 2'b10;
    pin_release();
    check("R3 no test voltage gives user", 16'(mon_mode), 16'h0);
    check("R5 user wdog", 16'(wdog_dis), 16'h0);
  endtask

  task automatic t_hv_entry();
    hv_irq = 1'b1; mode_sel = 2'b10; vec_blank = 1'b0;
    pin_release();
    check("R3 test voltage entry", 16'(mon_mode), 16'h1);
    check("R5 wdog with hv_irq", 16'(wdog_dis), 16'h1);
    hv_irq = 1'b0; hv_rst = 1'b1; mode_sel = 2'b00; vec_blank = 1'b1;
    cycles(2);
    check("R2 pins ignored after latch", 16'(mon_mode), 16'h1);
    check("R5 wdog with hv_rst", 16'(wdog_dis), 16'h1);
    hv_rst = 1'b0; vec_blank = 1'b0;
    cycles(1);
    check("R5 wdog follows voltage off", 16'(wdog_dis), 16'h0);
    hv_irq = 1'b1;
    cycles(1);
    check("R5 wdog follows voltage on", 16'(wdog_dis), 16'h1);
  endtask

  task automatic t_xlat_mon();
    vf_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      vf_addr = 16'hFFFC + 16'(k);
      cycles(1);
      check("R8 monitor vector remap", xlat_addr, 16'hFEFC + 16'(k));
    end
    vf_addr = 16'hFFFA;
    cycles(1);
    check("R9 other vector unchanged", xlat_addr, 16'hFFFA);
    vf_valid = 1'b0; vf_addr = 16'hFFFE;
    cycles(1);
    check("R9 data read unchanged", xlat_addr, 16'hFFFE);
    vf_valid = 1'b1;
  endtask

  task automatic t_hv_exit();
    hv_irq = 1'b0; hv_rst = 1'b0; mode_sel = 2'b00;
    pin_release();
    check("R6 test-voltage entry left by pin", 16'(mon_mode), 16'h0);
    vf_addr = 16'hFFFF;
    cycles(1);
    check("R8 user vector unchanged", xlat_addr, 16'hFFFF);
  endtask

  task automatic t_blank_entry();
    vec_blank = 1'b1; hv_irq = 1'b0; mode_sel = 2'b00;
    pin_release();
    check("R4 blank entry", 16'(mon_mode), 16'h1);
    check("R5 blank wdog", 16'(wdog_dis), 16'h1);
    vec_blank = 1'b0;
    pin_release();
    check("R6 pin release keeps blank entry", 16'(mon_mode), 16'h1);
    check("R5 blank wdog without voltage", 16'(wdog_dis), 16'h1);
    vf_addr = 16'hFFFE;
    cycles(1);
    check("R8 blank entry remaps", xlat_addr, 16'hFEFE);
  endtask

  task automatic t_por();
    por_pulse();
    check("R7 por clears mode", 16'(mon_mode), 16'h0);
    check("R7 por clears wdog", 16'(wdog_dis), 16'h0);
    hv_irq = 1'b1; mode_sel = 2'b10;
    pin_release();
    check("R7 fresh decision after por", 16'(mon_mode), 16'h1);
    por_pulse();
    check("R7 por clears test-voltage entry", 16'(mon_mode), 16'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_user_entry();
    t_hv_entry();
    t_xlat_mon();
    t_hv_exit();
    t_blank_entry();
    t_por();
    finish_run();
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule